// File: doc/BRIEF.md
# Pipelined Direct-Mapped Instruction Cache

This block is a small instruction cache for a 32-bit soft processor. It is direct-mapped, with one 32-bit word per line and 256 lines. The stored word and its tag share a single 72-bit storage word. That storage is built from a two-port RAM: both ports get the same line index, and each port gets its own top address bit. Each port then holds one 36-bit half, and together they behave as one single-port, double-width memory. All reads are synchronous and there is no asynchronous tag store. The fetch stage presents a word address, and the hit or miss verdict comes out one clock later, aligned with decode, together with the stored word.

The fetch side uses a valid/ready handshake. A lookup is accepted on a rising edge where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` simply mirrors `dec_ready`. While decode holds `dec_ready` low, no new lookup is accepted, and the decode-side outputs hold their values. The refill and invalidate pins are plain controls. A refill writes one word, its tag and a set valid bit in a single cycle, and no acknowledge is returned. An invalidate starts a sweep that clears every valid bit, one line per cycle. After reset the same sweep runs automatically.

The storage layout is as follows. The low half holds the data word and 4 spare bits, which are always zero. The high half holds a valid bit in bit 0, the 22-bit tag in bits 22:1, and 13 reserved bits, which are always zero.

Top module: `icache_pipe`

## Requirements
- R1: While reset is held, `dec_valid`, `dec_hit` and `dec_miss` are 0 and `busy` is 1. After release, `busy` stays 1 for exactly 256 rising edges, and one line is cleared on each of them.
- R2: A lookup accepted at an edge gives `dec_valid`=1 after that edge. Exactly one of `dec_hit` and `dec_miss` is then 1. An edge with `dec_ready`=1 and no accepted lookup gives `dec_valid`, `dec_hit` and `dec_miss` all 0.
- R3: The word address is split as follows: line index = `fetch_addr[7:0]`, tag = `fetch_addr[29:8]`. A lookup hits exactly when that line is valid and its stored tag equals the address tag.
- R4: On a hit, `dec_data` equals the last word refilled for that line. A later refill of the same index with a different tag replaces the line, and the old address then misses.
- R5: If a refill and a lookup address the same index in the same cycle, the lookup sees the contents from before the write. The next lookup of that index sees the new contents.
- R6: If a refill and a lookup in the same cycle address different indices, the refill takes the memory port and the lookup reports a miss.
- R7: While `dec_ready`=0, `fetch_ready` is 0 and no lookup is accepted. `dec_valid`, `dec_hit`, `dec_miss` and `dec_data` hold their values, even if a refill or sweep writes the memory.
- R8: `inval_req` sampled while `busy`=0 raises `busy` on the next edge. `busy` then stays high for 256 edges, after which every line is invalid.
- R9: A lookup accepted while `busy`=1 reports a miss. A refill presented while `busy`=1 is ignored.
- R10: `inval_req` sampled while `busy`=1 is ignored and does not lengthen the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Lookup request from fetch |
| fetch_ready | output | 1 | Lookup can be accepted (mirrors dec_ready) |
| fetch_addr | input | 30 | Word address to look up |
| dec_ready | input | 1 | Decode can take a result; low = stall |
| dec_valid | output | 1 | A lookup result is present |
| dec_hit | output | 1 | The present result is a hit |
| dec_miss | output | 1 | The present result is a miss |
| dec_data | output | 32 | Cached word (meaningful on hit) |
| refill_valid | input | 1 | Write one line this cycle |
| refill_addr | input | 30 | Word address of the refilled line |
| refill_data | input | 32 | Word to store |
| inval_req | input | 1 | Start clearing all lines |
| busy | output | 1 | Clearing sweep in progress |

## Verification
The assertions check on every cycle that a result follows an accepted lookup with one clock of latency. They also check that a present result is exactly one of hit or miss, and that the decode outputs are frozen during a stall. Further assertions check that lookups made while busy or while a refill conflicts at another index never hit, and that the sweep steps through consecutive lines and ends on the last one. Only the bench's reference model can show the rest. That covers whether a hit is correct against the refill history, whether the returned word is correct, the read-before-write result when a refill and a lookup share an index, and that every line is really invalid after a sweep.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned ADDR_W  = 30;  // word address width
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ENTRIES = 256;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned TAG_W   = ADDR_W - IDX_W;
  localparam int unsigned HALF_W  = 36;
  localparam int unsigned SPARE_W = HALF_W - DATA_W;
  localparam int unsigned RSVD_W  = HALF_W - TAG_W - 1;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic [DATA_W-1:0]  word;
  } lo_half_t;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [TAG_W-1:0]  tag;
    logic              vld;
  } hi_half_t;
endpackage

// File: rtl/icache_dpram.sv
module icache_dpram #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_re,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_re,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  // Synchronous ports, read-before-write; a read output only moves when read.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_re) a_rdata <= mem[a_addr];
    if (b_re) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HALF_W = 36,
  localparam int unsigned WW    = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             re,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WW-1:0]    wdata,
  output logic [WW-1:0]    rdata
);
  // Both ports share the line index; the page bit picks the half.
  icache_dpram #(.W(HALF_W), .DEPTH(2 ** (IDX_W + 1))) ram_i (
    .clk     (clk),
    .a_re    (re),
    .a_we    (we),
    .a_addr  ({1'b0, idx}),
    .a_wdata (wdata[HALF_W-1:0]),
    .a_rdata (rdata[HALF_W-1:0]),
    .b_re    (re),
    .b_we    (we),
    .b_addr  ({1'b1, idx}),
    .b_wdata (wdata[WW-1:HALF_W]),
    .b_rdata (rdata[WW-1:HALF_W])
  );
endmodule

// File: rtl/icache_sweep.sv
module icache_sweep #(
  parameter int unsigned ENTRIES = 256,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inval_req,
  output logic          busy,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
      if (idx == LAST) busy <= 1'b0;
    end else if (inval_req) begin
      busy <= 1'b1;
      idx  <= '0;
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1)); // R8
  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == LAST) |=> !busy); // R8
  AST_INVAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inval_req) |=> (busy && idx == '0)); // R8
  AST_INVAL_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != LAST && inval_req) |=> (idx != '0)); // R10
endmodule

// File: rtl/icache_pipe.sv
module icache_pipe
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              dec_ready,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_miss,
  output logic [DATA_W-1:0] dec_data,
  input  logic              refill_valid,
  input  logic [ADDR_W-1:0] refill_addr,
  input  logic [DATA_W-1:0] refill_data,
  input  logic              inval_req,
  output logic              busy
);
  logic [IDX_W-1:0]    f_idx, r_idx, sw_idx, mem_idx;
  logic [TAG_W-1:0]    f_tag, r_tag, lk_tag;
  logic                accept, refill_go, mem_we;
  logic                lk_valid, lk_force;
  lo_half_t            wr_lo, rd_lo;
  hi_half_t            wr_hi, rd_hi;
  logic [2*HALF_W-1:0] rd_word;

  assign fetch_ready = dec_ready;
  assign accept      = fetch_valid & dec_ready;
  assign f_idx       = fetch_addr[IDX_W-1:0];
  assign f_tag       = fetch_addr[ADDR_W-1:IDX_W];
  assign r_idx       = refill_addr[IDX_W-1:0];
  assign r_tag       = refill_addr[ADDR_W-1:IDX_W];
  assign refill_go   = refill_valid & ~busy;

  icache_sweep #(.ENTRIES(ENTRIES)) sweep_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inval_req (inval_req),
    .busy      (busy),
    .idx       (sw_idx)
  );

  // Port owner: sweep, then refill, then lookup.
  always_comb begin
    mem_we  = busy | refill_go;
    mem_idx = busy ? sw_idx : (refill_go ? r_idx : f_idx);
    wr_lo   = '{spare: '0, word: refill_data};
    wr_hi   = '{rsvd: '0, tag: r_tag, vld: ~busy};
  end

  icache_store #(.IDX_W(IDX_W), .HALF_W(HALF_W)) store_i (
    .clk   (clk),
    .re    (accept),
    .we    (mem_we),
    .idx   (mem_idx),
    .wdata ({wr_hi, wr_lo}),
    .rdata (rd_word)
  );

  // Lookup context travels one stage alongside the synchronous read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_tag   <= '0;
      lk_force <= 1'b0;
    end else if (dec_ready) begin
      lk_valid <= fetch_valid;
      if (fetch_valid) begin
        lk_tag   <= f_tag;
        lk_force <= busy | (refill_go & (r_idx != f_idx));
      end
    end
  end

  assign rd_lo     = lo_half_t'(rd_word[HALF_W-1:0]);
  assign rd_hi     = hi_half_t'(rd_word[2*HALF_W-1:HALF_W]);
  assign dec_hit   = lk_valid & ~lk_force & rd_hi.vld & (rd_hi.tag == lk_tag)
                   & (rd_hi.rsvd == '0) & (rd_lo.spare == '0);
  assign dec_miss  = lk_valid & ~dec_hit;
  assign dec_data  = rd_lo.word;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_hit ^ dec_miss)); // R2
  AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_hit && !dec_miss)); // R2
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && dec_ready) |=> dec_valid); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> ($stable(dec_valid) && $stable(dec_hit) && $stable(dec_data))); // R7
  AST_BUSY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && dec_ready && busy) |=> !dec_hit); // R9
  AST_CONFLICT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && dec_ready && refill_valid && !busy && (r_idx != f_idx)) |=> !dec_hit); // R6

  assign dec_valid = lk_valid;
endmodule

// File: tb/icache_pipe_tb.sv
`timescale 1ns/1ps
module icache_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0, dec_ready = 1'b1, refill_valid = 1'b0, inval_req = 1'b0;
  logic [29:0] fetch_addr = '0, refill_addr = '0;
  logic [31:0] refill_data = '0;
  logic        fetch_ready, dec_valid, dec_hit, dec_miss, busy;
  logic [31:0] dec_data;

  int n_chk = 0, n_err = 0;
  bit          m_v [256];
  logic [21:0] m_tag [256];
  logic [31:0] m_data [256];
  bit          m_busy = 1'b1;
  int          m_cnt = 0;
  bit          first_sweep = 1'b1;
  bit          e_dv = 1'b0, e_hit = 1'b0;
  logic [31:0] e_data = '0;

  always #2.5 clk = ~clk;

  icache_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .dec_ready(dec_ready), .dec_valid(dec_valid),
    .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_data(dec_data),
    .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_data(refill_data),
    .inval_req(inval_req), .busy(busy)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [29:0] wa(input int tag, input int idx);
    return {22'(tag), 8'(idx)};
  endfunction

  // One clock: drive inputs, advance the reference model, compare after the edge.
  task automatic step(input bit fv, input logic [29:0] fa, input bit rdy,
                      input bit rv, input logic [29:0] ra, input logic [31:0] rd, input bit inv);
    string lab, blab;
    int fi, ri;
    fetch_valid = fv; fetch_addr = fa; dec_ready = rdy;
    refill_valid = rv; refill_addr = ra; refill_data = rd; inval_req = inv;
    fi = int'(fa[7:0]); ri = int'(ra[7:0]);
    if (fv && rdy) begin
      e_dv = 1'b1;
      if (m_busy) begin e_hit = 1'b0; lab = "R9"; end
      else if (rv && ri != fi) begin e_hit = 1'b0; lab = "R6"; end
      else begin
        e_hit  = m_v[fi] && (m_tag[fi] == fa[29:8]);
        e_data = m_data[fi];
        lab    = rv ? "R5" : "R3";
      end
    end else if (rdy) begin
      e_dv = 1'b0; e_hit = 1'b0; lab = "R2";
    end else begin
      lab = "R7";
    end
    blab = (m_busy && inv) ? "R10" : (first_sweep ? "R1" : "R8");
    if (m_busy) begin
      m_v[m_cnt] = 1'b0;
      if (m_cnt == 255) begin m_busy = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end else begin
      if (rv) begin m_v[ri] = 1'b1; m_tag[ri] = ra[29:8]; m_data[ri] = rd; end
      if (inv) begin m_busy = 1'b1; m_cnt = 0; end
    end
    @(negedge clk);
    if (!m_busy) first_sweep = 1'b0;
    chk(lab, "dec_valid", 32'(dec_valid), 32'(e_dv));
    chk(lab, "dec_hit", 32'(dec_hit), 32'(e_hit));
    chk(lab, "dec_miss", 32'(dec_miss), 32'(e_dv && !e_hit));
    if (e_dv && e_hit) chk((lab == "R3") ? "R4" : lab, "dec_data", dec_data, e_data);
    chk(blab, "busy", 32'(busy), 32'(m_busy));
    chk("R7", "fetch_ready", 32'(fetch_ready), 32'(rdy));
  endtask

  task automatic look(input logic [29:0] a);
    step(1'b1, a, 1'b1, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(input logic [29:0] a, input logic [31:0] d);
    step(1'b0, '0, 1'b1, 1'b1, a, d, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "dec_valid in reset", 32'(dec_valid), 32'd0);
    chk("R1", "dec_miss in reset", 32'(dec_miss), 32'd0);
    chk("R1", "busy in reset", 32'(busy), 32'd1);
    rst_n = 1'b1;
    // R1 / R9 / R10: sweep after reset, with lookups, refills and invalidates ignored.
    for (int c = 0; c < 262; c++)
      step(c[0], wa(c % 3, c % 7), 1'b1, c[1], wa(1, c % 7), 32'hDEAD0000 + c, (c % 50) == 3);
    // R3 / R4: refill, hit, other tag misses, replacement.
    fill(wa(1, 5), 32'hA5A5_0001);
    look(wa(1, 5));
    look(wa(2, 5));
    fill(wa(2, 5), 32'hA5A5_0002);
    look(wa(1, 5));
    look(wa(2, 5));
    // R5: same-index refill and lookup in one cycle.
    step(1'b1, wa(3, 9), 1'b1, 1'b1, wa(3, 9), 32'h3333_0009, 1'b0);
    look(wa(3, 9));
    step(1'b1, wa(3, 9), 1'b1, 1'b1, wa(4, 9), 32'h4444_0009, 1'b0);
    look(wa(4, 9));
    // R6: refill at another index steals the port.
    step(1'b1, wa(4, 9), 1'b1, 1'b1, wa(5, 10), 32'h5555_000A, 1'b0);
    look(wa(5, 10));
    // R7: stall holds the result, even across a refill of the same line.
    look(wa(4, 9));
    step(1'b1, wa(2, 5), 1'b0, 1'b1, wa(6, 9), 32'h6666_0009, 1'b0);
    step(1'b1, wa(5, 10), 1'b0, 1'b0, '0, '0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0);
    look(wa(6, 9));
    // R8: invalidate, then everything misses.
    step(1'b0, '0, 1'b1, 1'b0, '0, '0, 1'b1);
    for (int c = 0; c < 258; c++) look(wa(c % 7, c % 11));
    look(wa(6, 9));
    look(wa(2, 5));
    // Random mix of everything.
    for (int c = 0; c < 6000; c++) begin
      int t1 = $urandom_range(0, 3), i1 = $urandom_range(0, 15);
      int t2 = $urandom_range(0, 3), i2 = $urandom_range(0, 15);
      step($urandom_range(0, 9) < 7, wa(t1, i1), $urandom_range(0, 9) < 8,
           $urandom_range(0, 3) == 0, wa(t2, i2), $urandom, $urandom_range(0, 999) < 3);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5 * 150000);
    n_err++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule